// File: doc/BRIEF.md
# Four-Channel Operating-System Match Timer

The block keeps one free-running 32-bit up-counter and four 32-bit compare registers. The counter advances by one on every clock in which the count-enable tick is high. It can be loaded at any time through the register port. When the counter steps onto a value held in a compare register, and that channel's interrupt enable is set, the channel raises a sticky flag. The flag drives the channel's own level interrupt line. Software acknowledges a flag by writing a one to its bit in the flag register.

Channel 3 also serves as a watchdog. If the arming register has bit 0 set when channel 3 matches, the block emits a one-cycle reset-request pulse and disarms itself by zeroing the arming register. This happens whatever the state of interrupt enable 3.

The register port is synchronous. It takes a 3-bit word index, a write strobe and write data, and it returns read data combinationally for the index presented.

Top module: `os_match_timer`

## Requirements
- R1: After synchronous reset, the counter, all four compare registers, the flag register, the interrupt-enable register and the arming register read zero, and all interrupt lines and the reset request are low.
- R2: Word index 4 (byte offset 0x10) reads the counter. The counter gains one on each clock with the tick high and no load. With the tick low it holds. It wraps from 0xFFFFFFFF to 0.
- R3: A write to word index 4 loads the counter with the written value on that clock. The load wins over a tick in the same cycle. A load never produces a match event, even when the loaded value equals a compare register.
- R4: A match event for channel i happens on a tick that moves the counter onto the value of compare register i. If interrupt-enable bit i is set, flag bit i (bit i of word index 5, byte offset 0x14) and interrupt line i go high at that same clock edge and stay high.
- R5: A match on a channel whose interrupt-enable bit is clear changes neither its flag bit nor its interrupt line.
- R6: A write to word index 5 clears each flag bit, and the matching interrupt line, wherever the written bit 0..3 is 1. Bits written as 0 are untouched. A match event in the same cycle wins over the clear.
- R7: Word index 7 (byte offset 0x1C) holds the interrupt enables. A write keeps only data bits 11:0, and bits 31:12 read as zero.
- R8: Word index 6 (byte offset 0x18) is the arming register and stores all 32 written bits. A channel-3 match event with arming bit 0 set produces a reset-request pulse exactly one clock wide, in the cycle after the match edge, and zeroes the arming register. This happens whether or not interrupt enable 3 is set, and it overrides an arming write in the same cycle.
- R9: Compare register i sits at word index i (byte offset 4*i, for i = 0..3). It stores and reads back all 32 written bits. The match test is pure 32-bit equality.
- R10: A counter that stays at a compare value while the tick is low creates no further events. Each equality reached by counting gives exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one count per high cycle |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_idx | input | 3 | Word index of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx (combinational) |
| irq | output | 4 | Level interrupt line per channel |
| rst_req | output | 1 | One-cycle reset-request pulse |

## Verification
On every cycle, the embedded properties check three things. The counter steps, holds or loads according to the tick and the write. An enabled match sets its flag on the next edge, a disabled channel's clear flag stays clear, and an acknowledge without a competing match clears the flag. The reset request is never longer than one cycle and always comes with a zeroed arming register.

Some behaviours only the bench's scenarios can show, because they depend on values reached across many cycles. These are wrap-around, a load onto a compare value staying silent, a held counter not firing again, the 12-bit masking of the enable register, and the watchdog firing with interrupt 3 disabled and only once per arming.

// File: rtl/ostm_pkg.sv
package ostm_pkg;

    localparam int NUM_CH  = 4;
    localparam int IDX_W   = 3;
    localparam int WDOG_CH = NUM_CH - 1;

    typedef enum logic [IDX_W-1:0] {
        SEL_CMP0  = 3'd0,
        SEL_CMP1  = 3'd1,
        SEL_CMP2  = 3'd2,
        SEL_CMP3  = 3'd3,
        SEL_COUNT = 3'd4,
        SEL_FLAGS = 3'd5,
        SEL_ARM   = 3'd6,
        SEL_IEN   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } reg_req_t;

    function automatic reg_req_t make_req(input logic wr, input logic [IDX_W-1:0] idx);
        reg_req_t r;
        r.wr  = wr;
        r.sel = reg_sel_e'(idx);
        return r;
    endfunction

    function automatic logic is_write(input reg_req_t r, input reg_sel_e s);
        return r.wr && (r.sel == s);
    endfunction

endpackage

// File: rtl/ostm_counter.sv
module ostm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_inc,
    output logic         adv
);

    assign cnt_inc = cnt_q + W'(1);
    assign adv     = tick && !ld;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (ld)   cnt_q <= ld_val;
        else if (tick) cnt_q <= cnt_inc;
    end

    // R2: counter holds when neither tick nor load
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> (cnt_q == $past(cnt_q)));

    // R2: counter steps by one on a tick
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R3: load wins over tick
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/ostm_channel.sv
module ostm_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] cnt_inc,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    input  logic         ien,
    input  logic         ack,
    output logic [W-1:0] cmp_q,
    output logic         hit,
    output logic         flag_q
);

    logic set_flag;

    assign hit      = adv && (cnt_inc == cmp_q);
    assign set_flag = hit && ien;

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (cmp_we) cmp_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (set_flag) flag_q <= 1'b1;
        else if (ack)      flag_q <= 1'b0;
    end

    // R4: enabled match raises the flag at the next edge
    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && ien) |=> flag_q);

    // R5: a disabled channel never raises a clear flag
    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!ien && !flag_q) |=> !flag_q);

    // R6: acknowledge clears unless a match competes
    p_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !(hit && ien)) |=> !flag_q);

endmodule

// File: rtl/ostm_watchdog.sv
module ostm_watchdog #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_we,
    input  logic [W-1:0] wdata,
    input  logic         ch_hit,
    output logic [W-1:0] arm_q,
    output logic         req_q
);

    logic fire;

    assign fire = ch_hit && arm_q[0];

    always_ff @(posedge clk) begin
        if (rst)         arm_q <= '0;
        else if (fire)   arm_q <= '0;
        else if (arm_we) arm_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= fire;
    end

    // R8: the request is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R8: a request always leaves the block disarmed
    p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (arm_q == '0));

    // R8: an armed channel-3 hit yields a request
    p_fire_r8: assert property (@(posedge clk) disable iff (rst)
        (ch_hit && arm_q[0]) |=> req_q);

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
    import ostm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IEN_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     reg_wr,
    input  logic [ostm_pkg::IDX_W-1:0] reg_idx,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [ostm_pkg::NUM_CH-1:0] irq,
    output logic                     rst_req
);

    reg_req_t           req;
    logic [DATA_W-1:0]  cnt_q;
    logic [DATA_W-1:0]  cnt_inc;
    logic               adv;
    logic [DATA_W-1:0]  cmp_q [NUM_CH];
    logic [NUM_CH-1:0]  hit;
    logic [NUM_CH-1:0]  flags;
    logic [IEN_W-1:0]   ien_q;
    logic [DATA_W-1:0]  arm_q;
    logic               ack_wr;

    assign req    = make_req(reg_wr, reg_idx);
    assign ack_wr = is_write(req, SEL_FLAGS);

    ostm_counter #(.W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ld      (is_write(req, SEL_COUNT)),
        .ld_val  (reg_wdata),
        .cnt_q   (cnt_q),
        .cnt_inc (cnt_inc),
        .adv     (adv)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ostm_channel #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .adv     (adv),
            .cnt_inc (cnt_inc),
            .cmp_we  (req.wr && (req.sel == reg_sel_e'(c))),
            .wdata   (reg_wdata),
            .ien     (ien_q[c]),
            .ack     (ack_wr && reg_wdata[c]),
            .cmp_q   (cmp_q[c]),
            .hit     (hit[c]),
            .flag_q  (flags[c])
        );
    end

    ostm_watchdog #(.W(DATA_W)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .arm_we (is_write(req, SEL_ARM)),
        .wdata  (reg_wdata),
        .ch_hit (hit[WDOG_CH]),
        .arm_q  (arm_q),
        .req_q  (rst_req)
    );

    always_ff @(posedge clk) begin
        if (rst)                        ien_q <= '0;
        else if (is_write(req, SEL_IEN)) ien_q <= reg_wdata[IEN_W-1:0];
    end

    assign irq = flags;

    always_comb begin
        reg_rdata = '0;
        case (req.sel)
            SEL_CMP0:  reg_rdata = cmp_q[0];
            SEL_CMP1:  reg_rdata = cmp_q[1];
            SEL_CMP2:  reg_rdata = cmp_q[2];
            SEL_CMP3:  reg_rdata = cmp_q[3];
            SEL_COUNT: reg_rdata = cnt_q;
            SEL_FLAGS: reg_rdata = DATA_W'(flags);
            SEL_ARM:   reg_rdata = arm_q;
            SEL_IEN:   reg_rdata = DATA_W'(ien_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R7: the enable register keeps its low bits from a write
    p_ien_r7: assert property (@(posedge clk) disable iff (rst)
        is_write(req, SEL_IEN) |=> (ien_q == $past(reg_wdata[IEN_W-1:0])));

endmodule

// File: tb/os_match_timer_tb_top.sv
module os_match_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq;
    logic        rst_req;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // reference model state
    logic [31:0] m_cnt;
    logic [31:0] m_cmp [4];
    logic [3:0]  m_flag;
    logic [11:0] m_ien;
    logic [31:0] m_arm;
    logic        m_req;

    always #10 clk = ~clk;

    os_match_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd4:    return m_cnt;
            3'd5:    return {28'd0, m_flag};
            3'd6:    return m_arm;
            3'd7:    return {20'd0, m_ien};
            default: return m_cmp[a];
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd4:    return "R2";
            3'd5:    return "R6";
            3'd6:    return "R8";
            3'd7:    return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_flag = '0; m_ien = '0; m_arm = '0; m_req = 1'b0;
        for (int i = 0; i < 4; i++) m_cmp[i] = '0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic [2:0] a,
                        input logic [31:0] d, input string scen);
        logic        ld, adv, fire;
        logic [31:0] inc;
        logic [3:0]  hitv;
        logic [3:0]  nf;
        logic [31:0] na;
        @(negedge clk);
        tick = t; reg_wr = w; reg_idx = a; reg_wdata = d;
        #1;
        chk("R4", {scen, " irq"}, {28'd0, irq}, {28'd0, m_flag});
        chk("R8", {scen, " rst_req"}, {31'd0, rst_req}, {31'd0, m_req});
        chk(read_tag(a), {scen, " rdata"}, reg_rdata, model_read(a));
        // next state from the requirements
        ld  = w && (a == 3'd4);
        adv = t && !ld;
        inc = m_cnt + 32'd1;
        for (int i = 0; i < 4; i++) hitv[i] = adv && (inc == m_cmp[i]);
        nf = m_flag;
        if (w && a == 3'd5) nf = nf & ~d[3:0];
        for (int i = 0; i < 4; i++) if (hitv[i] && m_ien[i]) nf[i] = 1'b1;
        fire = hitv[3] && m_arm[0];
        na = m_arm;
        if (w && a == 3'd6) na = d;
        if (fire) na = '0;
        @(posedge clk);
        if (ld) m_cnt = d; else if (t) m_cnt = inc;
        if (w && a < 3'd4) m_cmp[a[1:0]] = d;
        if (w && a == 3'd7) m_ien = d[11:0];
        m_flag = nf;
        m_arm  = na;
        m_req  = fire;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string s);
        step(1'b0, 1'b1, a, d, s);
    endtask

    task automatic rd(input logic [2:0] a, input string s);
        step(1'b0, 1'b0, a, 32'd0, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired, run hung");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) rd(3'(i), "R1 reset");

        // R9: compare registers store all bits
        for (int i = 0; i < 4; i++) wr(3'(i), 32'hA5C3_0F00 + 32'(i), "R9 write");
        for (int i = 0; i < 4; i++) rd(3'(i), "R9 readback");

        // R2: counting, holding and wrap
        wr(3'd4, 32'd0, "R3 load");
        repeat (5) step(1'b1, 1'b0, 3'd4, 32'd0, "R2 count");
        repeat (3) rd(3'd4, "R2 hold");
        wr(3'd4, 32'hFFFF_FFFE, "R3 load");
        repeat (3) step(1'b1, 1'b0, 3'd4, 32'd0, "R2 wrap");

        // R4: enabled matches raise flags
        wr(3'd7, 32'h0000_000F, "R7 enable");
        wr(3'd0, 32'h100, "R9"); wr(3'd1, 32'h102, "R9");
        wr(3'd2, 32'h200, "R9"); wr(3'd3, 32'h300, "R9");
        wr(3'd4, 32'hFE, "R3 load");
        repeat (5) step(1'b1, 1'b0, 3'd5, 32'd0, "R4 match");

        // R6: write-one-to-clear, set beats clear
        wr(3'd5, 32'h1, "R6 clear ch0");
        rd(3'd5, "R6 after clear");
        wr(3'd5, 32'hE, "R6 clear rest");
        wr(3'd4, 32'hFF, "R3 load");
        step(1'b1, 1'b1, 3'd5, 32'h1, "R6 set wins");
        rd(3'd5, "R6 set wins read");
        wr(3'd5, 32'hF, "R6 clear all");

        // R5: disabled channel ignores its match
        wr(3'd7, 32'hD, "R7 enable");
        wr(3'd4, 32'h101, "R3 load");
        step(1'b1, 1'b0, 3'd5, 32'd0, "R5 disabled match");
        rd(3'd5, "R5 status");

        // R7: enable register masks to 12 bits
        wr(3'd7, 32'hFFFF_FFFF, "R7 write");
        rd(3'd7, "R7 readback");

        // R8: watchdog with interrupt 3 disabled
        wr(3'd7, 32'h7, "R7 enable");
        wr(3'd6, 32'h0000_0001, "R8 arm");
        wr(3'd4, 32'h2FE, "R3 load");
        repeat (4) step(1'b1, 1'b0, 3'd6, 32'd0, "R8 fire");
        wr(3'd4, 32'h2FF, "R3 load");
        repeat (3) step(1'b1, 1'b0, 3'd6, 32'd0, "R8 no refire");
        wr(3'd6, 32'h1, "R8 arm");
        wr(3'd4, 32'h2FF, "R3 load");
        step(1'b1, 1'b1, 3'd6, 32'h1, "R8 fire beats arm write");
        repeat (2) rd(3'd6, "R8 disarmed");

        // R3: load beats tick; load onto compare value is silent
        wr(3'd7, 32'hF, "R7 enable");
        wr(3'd5, 32'hF, "R6 clear");
        step(1'b1, 1'b1, 3'd4, 32'h50, "R3 load with tick");
        rd(3'd4, "R3 count");
        wr(3'd4, 32'h200, "R3 load onto compare");
        rd(3'd5, "R3 no event");

        // R10: held counter at compare value fires once
        wr(3'd4, 32'h1FF, "R3 load");
        step(1'b1, 1'b0, 3'd5, 32'd0, "R10 hit");
        wr(3'd5, 32'hF, "R6 clear");
        repeat (5) rd(3'd5, "R10 held");

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            logic        t, w;
            logic [2:0]  a;
            logic [31:0] d;
            t = 1'($urandom % 2);
            w = (($urandom % 4) == 0);
            a = 3'($urandom % 8);
            if (a < 3'd4)       d = m_cnt + 32'($urandom % 8);
            else if (a == 3'd4) d = m_cmp[$urandom % 4] - 32'($urandom % 4);
            else if (a == 3'd5) d = 32'($urandom % 16);
            else if (a == 3'd6) d = 32'($urandom % 4);
            else                d = $urandom;
            step(t, w, a, d, "R2 R4 R6 mixed");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule